// File: doc/BRIEF.md
# Extended Capability Chain Manager

This block keeps a singly linked list of extended capability headers inside a word-addressed configuration RAM whose extended region starts at byte offset 256. Each header packs a 16-bit capability ID, a 4-bit version and a 12-bit byte offset of the following header. A next offset of zero ends the chain. A header word of zero at the base offset means the chain is empty.

Two commands are accepted while the block is idle. A lookup walks the chain from the base until the ID matches or the chain ends. It returns the matching offset and the offset of the entry that precedes it. If nothing matches, it returns the offset of the last entry visited. ID 0 is kept as a sentinel, so a lookup for ID 0 yields the chain tail. An insert writes a new header at a caller-given offset and links it in. At the base offset it keeps the stored next pointer. Anywhere else it finds the tail, rewrites only the tail's next field, and writes the new header with a null next pointer. It then emits one mask-clear strobe per configuration word of the new region. An external mask store uses these strobes to make the region read-only, not write-one-to-clear, and checked.

The RAM port is synchronous with one cycle of read latency. The block performs every read and write itself, one access per cycle.

Top module: `capchain_mgr`

## Requirements
- R1: A header word is laid out as ID in bits 15:0, version in bits 19:16 and next byte offset in bits 31:20. An insert writes its new header in this layout.
- R2: A lookup on a chain whose base header word is zero finishes with found=0, err=0, res_off=0 and res_prev=0 after exactly one RAM read.
- R3: A lookup that matches returns found=1, res_off set to the matching header's byte offset, and res_prev set to the offset of the header visited before it (0 when the match is at the base).
- R4: A lookup without a match returns found=0, res_off=0 and res_prev set to the offset of the last header in the chain. This includes a lookup for ID 0 on a chain that holds no ID-0 entry.
- R5: A non-zero next pointer that is not a multiple of 4, or lies outside 256..4088, ends the command with err=1 and found=0, and nothing is written. A pointer of exactly 4088 is followed.
- R6: A walk that would visit more than MAX_VISIT headers ends with err=1 after exactly MAX_VISIT reads.
- R7: An insert at offset 256 writes the new ID and version there, keeps the next field already stored at 256, and makes exactly one RAM write.
- R8: An insert at any other offset rewrites the tail header with its next field (bits 31:20) set to the new offset and its bits 19:0 unchanged. It then writes the new header with next=0 and returns res_off = new offset and res_prev = tail offset.
- R9: An insert at an offset other than 256 on an empty chain ends with err=1 and makes no RAM write.
- R10: After a successful insert, msk_we pulses once for each word index from off/4 to (off+size-1)/4, in ascending order, with msk_addr carrying the word index.
- R11: An insert with off<256, off not a multiple of 4, size=0 or off+size>=4096 is rejected with err=1 on the cycle after acceptance. It makes no RAM access and no mask strobe.
- R12: After reset the block is idle (busy=0, done=0, no RAM access). done is a one-cycle pulse, and cmd_valid is ignored while busy=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 1 | 0 = lookup, 1 = insert |
| cmd_id | input | 16 | Capability ID to look up or insert |
| cmd_ver | input | 4 | Version for insert |
| cmd_off | input | 12 | Byte offset for insert |
| cmd_size | input | 12 | Region size in bytes for insert |
| busy | output | 1 | Command in progress, including the done cycle |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Lookup matched, valid with done |
| err | output | 1 | Command failed, valid with done |
| res_off | output | 12 | Match offset (lookup) or new offset (insert) |
| res_prev | output | 12 | Preceding or tail offset |
| ram_req | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 10 | RAM word index |
| ram_wdata | output | 32 | RAM write data |
| ram_rdata | input | 32 | RAM read data, one cycle after a read request |
| msk_we | output | 1 | Mask-clear strobe for one word |
| msk_addr | output | 10 | Word index whose masks are cleared |

## Verification
The bench builds the block with the default 12-bit offset space, base 256 and 16/4/12 header split. This keeps the real upper pointer limit of 4088 and the 4096 size ceiling in reach, so both boundary pointers and a near-full insert can be driven. MAX_VISIT is lowered to 8, so a self-referencing header trips the loop guard after a short walk and the read count can be checked exactly.

// File: rtl/capchain_pkg.sv
package capchain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_PATCH,
        ST_WRITE,
        ST_MASK,
        ST_DONE
    } st_e;

    localparam logic OP_FIND = 1'b0;
    localparam logic OP_ADD  = 1'b1;

endpackage

// File: rtl/capchain_hdr.sv
// Splits a header word and judges its next pointer.
module capchain_hdr #(
    parameter int ID_W  = 16,
    parameter int VER_W = 4,
    parameter int OFF_W = 12,
    parameter int BASE  = 256
) (
    input  logic [ID_W+VER_W+OFF_W-1:0] hdr,
    output logic [ID_W-1:0]             id,
    output logic [OFF_W-1:0]            nxt,
    output logic                        nxt_bad
);
    localparam int                 SPACE  = 1 << OFF_W;
    localparam logic [OFF_W-1:0]   LO_LIM = OFF_W'(BASE);
    localparam logic [OFF_W-1:0]   HI_LIM = OFF_W'(SPACE - 8);

    assign id  = hdr[ID_W-1:0];
    assign nxt = hdr[ID_W+VER_W +: OFF_W];

    always_comb begin
        nxt_bad = (nxt != '0) &&
                  ((nxt < LO_LIM) || (nxt > HI_LIM) || (nxt[1:0] != 2'b00));
    end
endmodule

// File: rtl/capchain_argchk.sv
// Validates insert arguments and yields the word span of the region.
module capchain_argchk #(
    parameter int OFF_W = 12,
    parameter int BASE  = 256
) (
    input  logic [OFF_W-1:0] off,
    input  logic [OFF_W-1:0] size,
    output logic             bad,
    output logic [OFF_W-3:0] first_w,
    output logic [OFF_W-3:0] last_w
);
    localparam logic [OFF_W-1:0] LO_LIM = OFF_W'(BASE);

    logic [OFF_W:0]   span_end;
    logic [OFF_W-1:0] last_byte;

    always_comb begin
        span_end  = {1'b0, off} + {1'b0, size};
        last_byte = off + size - 1'b1;
        bad       = (off < LO_LIM) || (off[1:0] != 2'b00) ||
                    (size == '0) || span_end[OFF_W];
        first_w   = off[OFF_W-1:2];
        last_w    = last_byte[OFF_W-1:2];
    end
endmodule

// File: rtl/capchain_mgr.sv
module capchain_mgr
    import capchain_pkg::*;
#(
    parameter int ID_W      = 16,
    parameter int VER_W     = 4,
    parameter int OFF_W     = 12,
    parameter int BASE      = 256,
    parameter int MAX_VISIT = 1024
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_valid,
    input  logic                        cmd_op,
    input  logic [ID_W-1:0]             cmd_id,
    input  logic [VER_W-1:0]            cmd_ver,
    input  logic [OFF_W-1:0]            cmd_off,
    input  logic [OFF_W-1:0]            cmd_size,
    output logic                        busy,
    output logic                        done,
    output logic                        found,
    output logic                        err,
    output logic [OFF_W-1:0]            res_off,
    output logic [OFF_W-1:0]            res_prev,
    output logic                        ram_req,
    output logic                        ram_we,
    output logic [OFF_W-3:0]            ram_addr,
    output logic [ID_W+VER_W+OFF_W-1:0] ram_wdata,
    input  logic [ID_W+VER_W+OFF_W-1:0] ram_rdata,
    output logic                        msk_we,
    output logic [OFF_W-3:0]            msk_addr
);
    localparam int               WA_W  = OFF_W - 2;
    localparam int               LO_W  = ID_W + VER_W;
    localparam int               CNT_W = $clog2(MAX_VISIT + 1);
    localparam logic [OFF_W-1:0] BASE_O = OFF_W'(BASE);

    typedef struct packed {
        st_e              st;
        logic             add;
        logic [ID_W-1:0]  id;
        logic [VER_W-1:0] ver;
        logic [OFF_W-1:0] off;
        logic [OFF_W-1:0] cur;
        logic [OFF_W-1:0] prev;
        logic [LO_W-1:0]  tail_lo;
        logic [OFF_W-1:0] nxt;
        logic [WA_W-1:0]  mw;
        logic [WA_W-1:0]  mend;
        logic [CNT_W-1:0] cnt;
        logic             found;
        logic             err;
        logic [OFF_W-1:0] r_off;
        logic [OFF_W-1:0] r_prev;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [ID_W-1:0]  h_id;
    logic [OFF_W-1:0] h_nxt;
    logic             h_bad;
    logic             arg_bad;
    logic [WA_W-1:0]  arg_first, arg_last;
    logic [CNT_W-1:0] cnt_nx;

    capchain_hdr #(
        .ID_W (ID_W),
        .VER_W(VER_W),
        .OFF_W(OFF_W),
        .BASE (BASE)
    ) u_hdr (
        .hdr    (ram_rdata),
        .id     (h_id),
        .nxt    (h_nxt),
        .nxt_bad(h_bad)
    );

    capchain_argchk #(
        .OFF_W(OFF_W),
        .BASE (BASE)
    ) u_arg (
        .off    (cmd_off),
        .size   (cmd_size),
        .bad    (arg_bad),
        .first_w(arg_first),
        .last_w (arg_last)
    );

    always_comb begin
        ctx_d  = ctx_q;
        cnt_nx = ctx_q.cnt + 1'b1;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    ctx_d.add    = (cmd_op == OP_ADD);
                    ctx_d.id     = cmd_id;
                    ctx_d.ver    = cmd_ver;
                    ctx_d.off    = cmd_off;
                    ctx_d.cur    = BASE_O;
                    ctx_d.prev   = '0;
                    ctx_d.nxt    = '0;
                    ctx_d.mw     = arg_first;
                    ctx_d.mend   = arg_last;
                    ctx_d.cnt    = '0;
                    ctx_d.found  = 1'b0;
                    ctx_d.err    = 1'b0;
                    ctx_d.r_off  = '0;
                    ctx_d.r_prev = '0;
                    if (cmd_op == OP_ADD && arg_bad) begin
                        ctx_d.err = 1'b1;
                        ctx_d.st  = ST_DONE;
                    end else begin
                        ctx_d.st  = ST_READ;
                    end
                end
            end
            ST_READ: ctx_d.st = ST_EVAL;
            ST_EVAL: begin
                ctx_d.cnt     = cnt_nx;
                ctx_d.tail_lo = ram_rdata[LO_W-1:0];
                if (ctx_q.add && ctx_q.off == BASE_O) begin
                    // insert at the base keeps the stored link
                    ctx_d.nxt = h_nxt;
                    ctx_d.st  = ST_WRITE;
                end else if (ctx_q.cur == BASE_O && ram_rdata == '0) begin
                    ctx_d.err = ctx_q.add;
                    ctx_d.st  = ST_DONE;
                end else if (!ctx_q.add && h_id == ctx_q.id) begin
                    ctx_d.found  = 1'b1;
                    ctx_d.r_off  = ctx_q.cur;
                    ctx_d.r_prev = ctx_q.prev;
                    ctx_d.st     = ST_DONE;
                end else if (h_nxt == '0) begin
                    ctx_d.prev   = ctx_q.cur;
                    ctx_d.r_prev = ctx_q.cur;
                    ctx_d.nxt    = '0;
                    ctx_d.st     = ctx_q.add ? ST_PATCH : ST_DONE;
                end else if (h_bad || cnt_nx == CNT_W'(MAX_VISIT)) begin
                    ctx_d.err = 1'b1;
                    ctx_d.st  = ST_DONE;
                end else begin
                    ctx_d.prev = ctx_q.cur;
                    ctx_d.cur  = h_nxt;
                    ctx_d.st   = ST_READ;
                end
            end
            ST_PATCH: ctx_d.st = ST_WRITE;
            ST_WRITE: begin
                ctx_d.r_off = ctx_q.off;
                ctx_d.st    = ST_MASK;
            end
            ST_MASK: begin
                ctx_d.mw = ctx_q.mw + 1'b1;
                if (ctx_q.mw == ctx_q.mend) begin
                    ctx_d.st = ST_DONE;
                end
            end
            ST_DONE: ctx_d.st = ST_IDLE;
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q    <= '0;
            ctx_q.st <= ST_IDLE;
        end else begin
            ctx_q    <= ctx_d;
        end
    end

    always_comb begin
        ram_req   = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = ctx_q.cur[OFF_W-1:2];
        ram_wdata = '0;
        unique case (ctx_q.st)
            ST_READ: ram_req = 1'b1;
            ST_PATCH: begin
                ram_req   = 1'b1;
                ram_we    = 1'b1;
                ram_addr  = ctx_q.prev[OFF_W-1:2];
                ram_wdata = {ctx_q.off, ctx_q.tail_lo};
            end
            ST_WRITE: begin
                ram_req   = 1'b1;
                ram_we    = 1'b1;
                ram_addr  = ctx_q.off[OFF_W-1:2];
                ram_wdata = {ctx_q.nxt, ctx_q.ver, ctx_q.id};
            end
            default: ;
        endcase
    end

    assign msk_we   = (ctx_q.st == ST_MASK);
    assign msk_addr = ctx_q.mw;
    assign busy     = (ctx_q.st != ST_IDLE);
    assign done     = (ctx_q.st == ST_DONE);
    assign found    = ctx_q.found;
    assign err      = ctx_q.err;
    assign res_off  = ctx_q.r_off;
    assign res_prev = ctx_q.r_prev;

endmodule

// File: rtl/capchain_chk.sv
module capchain_chk #(
    parameter int OFF_W = 12,
    parameter int BASE  = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_op,
    input logic [OFF_W-1:0] cmd_off,
    input logic             busy,
    input logic             done,
    input logic             found,
    input logic             err,
    input logic             ram_req,
    input logic [OFF_W-3:0] ram_addr,
    input logic             msk_we
);
    localparam logic [OFF_W-1:0] BASE_O = OFF_W'(BASE);
    localparam logic [OFF_W-3:0] BASE_W = BASE_O[OFF_W-1:2];

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    // R11
    low_off_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op && (cmd_off < BASE_O)) |=> (done && err && !ram_req));

    // R5
    ram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req |-> (ram_addr >= BASE_W));

    // R10
    mask_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msk_we |-> (busy && !ram_req && !done));

    // R3
    found_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> !err);
endmodule

bind capchain_mgr capchain_chk #(
    .OFF_W(OFF_W),
    .BASE (BASE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_off  (cmd_off),
    .busy     (busy),
    .done     (done),
    .found    (found),
    .err      (err),
    .ram_req  (ram_req),
    .ram_addr (ram_addr),
    .msk_we   (msk_we)
);

// File: tb/tb_capchain_mgr.sv
`timescale 1ns/1ps
module tb_capchain_mgr;
    localparam int ID_W = 16, VER_W = 4, OFF_W = 12, MAXV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_op = 1'b0;
    logic [15:0] cmd_id = '0;
    logic [3:0]  cmd_ver = '0;
    logic [11:0] cmd_off = '0, cmd_size = '0;
    logic        busy, done, found, err;
    logic [11:0] res_off, res_prev;
    logic        ram_req, ram_we, msk_we;
    logic [9:0]  ram_addr, msk_addr;
    logic [31:0] ram_wdata, ram_rdata;

    always #2 clk = ~clk;

    capchain_mgr #(.ID_W(ID_W), .VER_W(VER_W), .OFF_W(OFF_W), .BASE(256), .MAX_VISIT(MAXV)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id),
        .cmd_ver(cmd_ver), .cmd_off(cmd_off), .cmd_size(cmd_size), .busy(busy), .done(done),
        .found(found), .err(err), .res_off(res_off), .res_prev(res_prev), .ram_req(ram_req),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .msk_we(msk_we), .msk_addr(msk_addr));

    logic [31:0] mem [1024];
    int rd_cnt = 0, wr_cnt = 0, msk_cnt = 0;
    logic [9:0] msk_last = '0;

    always @(posedge clk) begin
        if (ram_req) begin
            if (ram_we) begin
                mem[ram_addr] <= ram_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                ram_rdata <= mem[ram_addr];
                rd_cnt <= rd_cnt + 1;
            end
        end
        if (msk_we) begin
            msk_cnt <= msk_cnt + 1;
            msk_last <= msk_addr;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic g_found, g_err, g_done_after;
    logic [11:0] g_off, g_prev;
    int d_rd, d_wr, d_msk;

    function automatic logic [31:0] hdr(input logic [15:0] id, input logic [3:0] ver,
                                        input logic [11:0] nxt);
        return {nxt, ver, id};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic op, input logic [15:0] id, input logic [3:0] ver,
                       input logic [11:0] off, input logic [11:0] size);
        int r0, w0, m0, n;
        r0 = rd_cnt; w0 = wr_cnt; m0 = msk_cnt;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_id = id; cmd_ver = ver;
        cmd_off = off; cmd_size = size;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("watchdog: command did not finish", {31'b0, done}, 32'd1);
        g_found = found; g_err = err; g_off = res_off; g_prev = res_prev;
        d_rd = rd_cnt - r0; d_wr = wr_cnt - w0; d_msk = msk_cnt - m0;
        @(negedge clk);
        g_done_after = done;
    endtask

    task automatic t_reset();
        chk("R12 reset busy", {31'b0, busy}, 0);
        chk("R12 reset done", {31'b0, done}, 0);
        chk("R12 reset ram_req", {31'b0, ram_req}, 0);
    endtask

    task automatic t_empty();
        run(0, 16'h0001, 0, 0, 0);
        chk("R2 empty found", {31'b0, g_found}, 0);
        chk("R2 empty err", {31'b0, g_err}, 0);
        chk("R2 empty off", {20'b0, g_off}, 0);
        chk("R2 empty prev", {20'b0, g_prev}, 0);
        chk("R2 empty reads", d_rd, 1);
        chk("R12 done pulse", {31'b0, g_done_after}, 0);
    endtask

    task automatic t_build();
        run(1, 16'h0001, 4'h1, 12'h100, 12'd8);
        chk("R1 first header", mem[64], hdr(16'h0001, 4'h1, 12'h000));
        chk("R7 base insert writes", d_wr, 1);
        chk("R10 mask count a", d_msk, 2);
        chk("R10 mask last a", {22'b0, msk_last}, 65);
        run(1, 16'h000E, 4'h2, 12'h140, 12'd16);
        chk("R8 tail patched", mem[64], hdr(16'h0001, 4'h1, 12'h140));
        chk("R1 new header", mem[80], hdr(16'h000E, 4'h2, 12'h000));
        chk("R8 res_prev", {20'b0, g_prev}, 32'h100);
        chk("R8 res_off", {20'b0, g_off}, 32'h140);
        chk("R10 mask count b", d_msk, 4);
        chk("R10 mask last b", {22'b0, msk_last}, 83);
        run(1, 16'h0010, 4'h1, 12'h200, 12'd12);
        chk("R8 second patch", mem[80], hdr(16'h000E, 4'h2, 12'h200));
        chk("R8 second new", mem[128], hdr(16'h0010, 4'h1, 12'h000));
        chk("R8 writes", d_wr, 2);
        chk("R10 mask count c", d_msk, 3);
    endtask

    task automatic t_find();
        run(0, 16'h000E, 0, 0, 0);
        chk("R3 mid found", {31'b0, g_found}, 1);
        chk("R3 mid off", {20'b0, g_off}, 32'h140);
        chk("R3 mid prev", {20'b0, g_prev}, 32'h100);
        run(0, 16'h0001, 0, 0, 0);
        chk("R3 head off", {20'b0, g_off}, 32'h100);
        chk("R3 head prev", {20'b0, g_prev}, 0);
        run(0, 16'h0010, 0, 0, 0);
        chk("R3 tail off", {20'b0, g_off}, 32'h200);
        chk("R3 tail prev", {20'b0, g_prev}, 32'h140);
        chk("R3 tail reads", d_rd, 3);
    endtask

    task automatic t_miss();
        run(0, 16'h0055, 0, 0, 0);
        chk("R4 miss found", {31'b0, g_found}, 0);
        chk("R4 miss off", {20'b0, g_off}, 0);
        chk("R4 miss prev", {20'b0, g_prev}, 32'h200);
        run(0, 16'h0000, 0, 0, 0);
        chk("R4 sentinel prev", {20'b0, g_prev}, 32'h200);
        chk("R4 sentinel err", {31'b0, g_err}, 0);
    endtask

    task automatic t_head();
        run(1, 16'h0023, 4'h3, 12'h100, 12'd4);
        chk("R7 keeps link", mem[64], hdr(16'h0023, 4'h3, 12'h140));
        chk("R7 one write", d_wr, 1);
        chk("R10 one mask", d_msk, 1);
        chk("R10 mask addr", {22'b0, msk_last}, 64);
        run(0, 16'h0010, 0, 0, 0);
        chk("R7 chain intact", {20'b0, g_off}, 32'h200);
    endtask

    task automatic t_fault();
        mem[128] = hdr(16'h0010, 4'h1, 12'h202);
        run(0, 16'h0099, 0, 0, 0);
        chk("R5 misaligned err", {31'b0, g_err}, 1);
        chk("R5 misaligned found", {31'b0, g_found}, 0);
        mem[128] = hdr(16'h0010, 4'h1, 12'hFFC);
        run(0, 16'h0099, 0, 0, 0);
        chk("R5 high err", {31'b0, g_err}, 1);
        mem[128] = hdr(16'h0010, 4'h1, 12'h080);
        run(1, 16'h0099, 4'h1, 12'h300, 12'd4);
        chk("R5 low err on insert", {31'b0, g_err}, 1);
        chk("R5 no write", d_wr, 0);
        mem[128] = hdr(16'h0010, 4'h1, 12'hFF8);
        mem[1022] = hdr(16'h0030, 4'h1, 12'h000);
        run(0, 16'h0030, 0, 0, 0);
        chk("R5 edge found", {31'b0, g_found}, 1);
        chk("R5 edge off", {20'b0, g_off}, 32'hFF8);
        mem[128] = hdr(16'h0010, 4'h1, 12'h000);
    endtask

    task automatic t_loop();
        mem[64] = hdr(16'h0023, 4'h3, 12'h100);
        run(0, 16'h0077, 0, 0, 0);
        chk("R6 loop err", {31'b0, g_err}, 1);
        chk("R6 loop reads", d_rd, MAXV);
    endtask

    task automatic t_empty_add();
        mem[64] = '0;
        run(1, 16'h0044, 4'h1, 12'h300, 12'd4);
        chk("R9 empty insert err", {31'b0, g_err}, 1);
        chk("R9 no write", d_wr, 0);
        chk("R9 no mask", d_msk, 0);
    endtask

    task automatic t_args();
        run(1, 16'h0044, 4'h1, 12'h080, 12'd4);
        chk("R11 low off err", {31'b0, g_err}, 1);
        chk("R11 low off no read", d_rd, 0);
        run(1, 16'h0044, 4'h1, 12'h102, 12'd4);
        chk("R11 unaligned err", {31'b0, g_err}, 1);
        run(1, 16'h0044, 4'h1, 12'h100, 12'd0);
        chk("R11 zero size err", {31'b0, g_err}, 1);
        run(1, 16'h0044, 4'h1, 12'hF00, 12'h100);
        chk("R11 overflow err", {31'b0, g_err}, 1);
        chk("R11 no access", d_rd + d_wr + d_msk, 0);
        run(1, 16'h0044, 4'h1, 12'h100, 12'hEFF);
        chk("R11 max span ok", {31'b0, g_err}, 0);
        chk("R10 max span masks", d_msk, 960);
        chk("R10 max span last", {22'b0, msk_last}, 1023);
    endtask

    task automatic t_busy();
        int w0, n;
        mem[64] = hdr(16'h0001, 4'h1, 12'h140);
        mem[80] = hdr(16'h000E, 4'h2, 12'h000);
        w0 = wr_cnt;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 1'b0; cmd_id = 16'h0055;
        @(negedge clk);
        cmd_op = 1'b1; cmd_id = 16'h0066; cmd_off = 12'h300; cmd_size = 12'd4;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R12 find result prev", {20'b0, res_prev}, 32'h140);
        @(negedge clk);
        chk("R12 idle after done", {31'b0, busy}, 0);
        repeat (3) @(negedge clk);
        chk("R12 ignored while busy", wr_cnt - w0, 0);
        chk("R12 still idle", {31'b0, busy}, 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        ram_rdata = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_build();
        t_find();
        t_miss();
        t_head();
        t_fault();
        t_loop();
        t_empty_add();
        t_args();
        t_busy();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule